// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer for One Buck Phase

This block sits between the pulse-width decision of one synchronous buck phase and its two gate drivers. A single high-side request from the modulator becomes two gate enables, one for the upper switch and one for the lower switch. The dead time between them is not a fixed count. It closes on two threshold flags that analog comparators deliver as synchronous inputs. One flag reports that the switch node has dropped below roughly 2.2 V. The other reports that the lower gate has discharged below roughly 1.2 V. The upper switch also waits a fixed, programmable number of cycles after the lower gate is seen low.

Two fault inputs override normal switching. An overcurrent trip turns the upper switch off and the lower switch on, and holds that state until the sensed current is back at zero. The block then issues a one-cycle soft-start request and returns to idle. An over-voltage trip latches the lower switch on and the upper switch off, and only a reset clears it. The reset input stands for a supply cycle. Each wait for a flag has a timeout, so a comparator that is stuck cannot hang the phase. A current-valid strobe tells the current sensor when the lower switch is conducting.

Top module: `phase_gate_sequencer`

## Requirements
- R1: While reset is low, and afterwards until `hs_req` is first seen high, both gate enables, `isense_valid` and `softstart_req` are 0.
- R2: `hs_gate_en` stays 1 for as long as `hs_req` stays high. It clears on the first clock edge that samples `hs_req` low. It only ever rises after a cycle in which both enables were 0.
- R3: After the upper switch turns off, `ls_gate_en` stays 0 until `sw_node_low` is sampled high. It rises on that same edge.
- R4: If the awaited flag (`sw_node_low` or `lo_gate_low`) never arrives, the wait ends after `WAIT_MAX` cycles and the sequence continues as if the flag had arrived.
- R5: When `hs_req` rises while the lower switch is on, `ls_gate_en` drops at once. `hs_gate_en` rises only `HS_DLY_CYC`+1 edges after `lo_gate_low` is first sampled high in the wait.
- R6: If `hs_req` falls while the block is waiting for the lower gate or is in the fixed delay, the lower switch turns back on at the next edge and the upper switch never turns on.
- R7: `isense_valid` is 1 exactly in the cycles in which `ls_gate_en` is 1.
- R8: A sampled `oc_trip` forces `hs_gate_en`=0 and `ls_gate_en`=1 at the next edge, from any state except the over-voltage latch. The hold ends at the first edge where `oc_trip` is low and `cur_zero` is high. That edge raises `softstart_req` for exactly one cycle and leaves both enables at 0.
- R9: A sampled `ov_trip` forces `ls_gate_en`=1 and `hs_gate_en`=0 at the next edge. This state ignores every other input and never issues `softstart_req` until reset.
- R10: When `ov_trip` and `oc_trip` are sampled together, the over-voltage behaviour (R9) wins.
- R11: `hs_gate_en` and `ls_gate_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset (supply-cycle reset) |
| hs_req | input | 1 | Upper-switch on-request from the modulator |
| sw_node_low | input | 1 | Switch node below the low threshold |
| lo_gate_low | input | 1 | Lower gate voltage below its off threshold |
| oc_trip | input | 1 | Overcurrent comparator output |
| cur_zero | input | 1 | Sensed phase current has returned to zero |
| ov_trip | input | 1 | Feedback above the over-voltage level |
| hs_gate_en | output | 1 | Upper-switch gate enable |
| ls_gate_en | output | 1 | Lower-switch gate enable |
| isense_valid | output | 1 | Current sense sample is meaningful |
| softstart_req | output | 1 | One-cycle request to restart with soft start |

## Verification
Every cycle, the assertions check that the two enables never overlap. They also check that an upper turn-on is preceded by a dead cycle, and that a lower turn-on during normal switching never follows an upper-on cycle. They further check that the over-voltage latch is sticky and that a soft-start request is always caused by a zero-current sample in the overcurrent hold. The bench scenarios show the rest. These are the exact dead-time lengths after each flag, the timeout fall-through on both waits, and the return to the lower switch when a request is withdrawn. They also cover the single soft-start pulse and the over-voltage state ignoring later inputs until reset.

// File: rtl/gs_pkg.sv
// Package: shared state encoding for the phase gate sequencer.
// Assumes nothing beyond a 3-bit state register.
package gs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HS_ON    = 3'd1,
        ST_WAIT_SW  = 3'd2,
        ST_LS_ON    = 3'd3,
        ST_WAIT_LG  = 3'd4,
        ST_HS_DLY   = 3'd5,
        ST_OC_HOLD  = 3'd6,
        ST_OV_LATCH = 3'd7
    } seq_state_t;
endpackage

// File: rtl/gs_wait_timer.sv
// gs_wait_timer: dwell counter for the sequencer states.
// Cleared whenever the state changes and saturating at all ones. It
// reports when the flag-wait limit and the fixed turn-on delay are reached.
// Assumes WAIT_MAX and DLY_CYC are at least 1 and fit in CNT_W bits.
module gs_wait_timer #(
    parameter int CNT_W    = 4,
    parameter int WAIT_MAX = 8,
    parameter int DLY_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tmo_hit,
    output logic dly_hit
);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(WAIT_MAX - 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles spent in the current state, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the dwell count against both limits.
    always_comb begin
        tmo_hit = (cnt_q == TMO_LAST);
        dly_hit = (cnt_q == DLY_LAST);
    end

    // A restart always brings the count back to zero for the next cycle.
    assert_timer_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/gs_fault_arbiter.sv
// gs_fault_arbiter: ranks the fault overrides.
// The over-voltage condition (a fresh trip or the held latch) beats
// overcurrent, and overcurrent beats normal switching.
// Assumes the trip inputs are already synchronous to clk.
module gs_fault_arbiter (
    input  logic ov_trip,
    input  logic oc_trip,
    input  logic ov_held,
    output logic go_ov,
    output logic go_oc
);
    // Apply the fixed priority between the two overrides.
    always_comb begin
        go_ov = ov_trip | ov_held;
        go_oc = oc_trip & ~go_ov;
    end
endmodule

// File: rtl/gs_seq_fsm.sv
// gs_seq_fsm: state register and transition logic of the sequencer.
// Normal switching closes the dead time on the node and gate flags, and
// each wait falls through on timeout. The fault overrides come from the
// arbiter. The soft-start request is registered from the overcurrent-hold exit.
module gs_seq_fsm
    import gs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_req,
    input  logic       sw_low,
    input  logic       lg_low,
    input  logic       cur_zero,
    input  logic       go_ov,
    input  logic       go_oc,
    input  logic       tmo_hit,
    input  logic       dly_hit,
    output seq_state_t state_q,
    output logic       restart,
    output logic       ss_q
);
    seq_state_t state_d;
    logic       oc_exit;

    // Choose the next state: faults first, then the switching sequence.
    always_comb begin
        state_d = state_q;
        oc_exit = 1'b0;
        if (go_ov) begin
            state_d = ST_OV_LATCH;
        end else if (go_oc) begin
            state_d = ST_OC_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (hs_req) state_d = ST_WAIT_LG;
                ST_HS_ON:   if (!hs_req) state_d = ST_WAIT_SW;
                ST_WAIT_SW: if (sw_low || tmo_hit) state_d = ST_LS_ON;
                ST_LS_ON:   if (hs_req) state_d = ST_WAIT_LG;
                ST_WAIT_LG: begin
                    if (!hs_req)                state_d = ST_LS_ON;
                    else if (lg_low || tmo_hit) state_d = ST_HS_DLY;
                end
                ST_HS_DLY: begin
                    if (!hs_req)      state_d = ST_LS_ON;
                    else if (dly_hit) state_d = ST_HS_ON;
                end
                ST_OC_HOLD: begin
                    if (cur_zero) begin
                        state_d = ST_IDLE;
                        oc_exit = 1'b1;
                    end
                end
                ST_OV_LATCH: state_d = ST_OV_LATCH;
                default:     state_d = ST_IDLE;
            endcase
        end
        restart = (state_d != state_q);
    end

    // Hold the state and the one-cycle soft-start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ss_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ss_q    <= oc_exit;
        end
    end

    // Once latched, over-voltage is left only through reset.
    assert_ov_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_LATCH) |=> (state_q == ST_OV_LATCH));

    // A soft-start request follows a zero-current sample in the hold.
    assert_ss_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_q |-> ($past(state_q) == ST_OC_HOLD && $past(cur_zero)));

    // A low node flag in the node wait, with no fault, reaches the lower switch.
    assert_sw_flag_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SW && sw_low && !go_ov && !go_oc) |=> (state_q == ST_LS_ON));
endmodule

// File: rtl/gs_gate_decode.sv
// gs_gate_decode: turns the sequencer state into the gate enables and the
// current-sense strobe. Outputs depend only on the state register, so
// they change only on a clock edge.
module gs_gate_decode
    import gs_pkg::*;
(
    input  seq_state_t state_q,
    output logic       hs_en,
    output logic       ls_en,
    output logic       isense_ok
);
    // Map each state to its gate pattern.
    always_comb begin
        hs_en     = 1'b0;
        ls_en     = 1'b0;
        isense_ok = 1'b0;
        unique case (state_q)
            ST_HS_ON: hs_en = 1'b1;
            ST_LS_ON, ST_OC_HOLD, ST_OV_LATCH: begin
                ls_en     = 1'b1;
                isense_ok = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phase_gate_sequencer.sv
// phase_gate_sequencer: top of the adaptive dead-time gate sequencer for
// one buck phase. Assumes all comparator flags and trips are synchronous
// to clk. rst_n models the supply-cycle reset that clears over-voltage.
module phase_gate_sequencer
    import gs_pkg::*;
#(
    parameter int WAIT_MAX   = 8,
    parameter int HS_DLY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic sw_node_low,
    input  logic lo_gate_low,
    input  logic oc_trip,
    input  logic cur_zero,
    input  logic ov_trip,
    output logic hs_gate_en,
    output logic ls_gate_en,
    output logic isense_valid,
    output logic softstart_req
);
    localparam int LIMIT = (WAIT_MAX > HS_DLY_CYC) ? WAIT_MAX : HS_DLY_CYC;
    localparam int CNT_W = $clog2(LIMIT + 1);

    seq_state_t state_q;
    logic       restart;
    logic       tmo_hit;
    logic       dly_hit;
    logic       go_ov;
    logic       go_oc;
    logic       ov_held;
    logic       armed_q;

    // Flag the held over-voltage state for the arbiter.
    always_comb ov_held = (state_q == ST_OV_LATCH);

    gs_fault_arbiter u_arb (
        .ov_trip (ov_trip),
        .oc_trip (oc_trip),
        .ov_held (ov_held),
        .go_ov   (go_ov),
        .go_oc   (go_oc)
    );

    gs_wait_timer #(
        .CNT_W    (CNT_W),
        .WAIT_MAX (WAIT_MAX),
        .DLY_CYC  (HS_DLY_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tmo_hit (tmo_hit),
        .dly_hit (dly_hit)
    );

    gs_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_req   (hs_req),
        .sw_low   (sw_node_low),
        .lg_low   (lo_gate_low),
        .cur_zero (cur_zero),
        .go_ov    (go_ov),
        .go_oc    (go_oc),
        .tmo_hit  (tmo_hit),
        .dly_hit  (dly_hit),
        .state_q  (state_q),
        .restart  (restart),
        .ss_q     (softstart_req)
    );

    gs_gate_decode u_dec (
        .state_q   (state_q),
        .hs_en     (hs_gate_en),
        .ls_en     (ls_gate_en),
        .isense_ok (isense_valid)
    );

    // Mark the cycles whose history lies entirely after reset.
    always_ff @(posedge clk) begin
        armed_q <= rst_n;
    end

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_en && ls_gate_en));

    assert_dead_before_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(hs_gate_en)) |-> !$past(ls_gate_en));

    assert_ls_after_hs_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(ls_gate_en) && !$past(oc_trip) && !$past(ov_trip))
            |-> !$past(hs_gate_en));

    assert_ov_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ov_trip)) |-> (ls_gate_en && !hs_gate_en && !softstart_req));

    assert_isense_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        isense_valid == ls_gate_en);
endmodule

// File: tb/test_phase_gate_sequencer.sv
module test_phase_gate_sequencer;
    localparam int WAIT_MAX   = 8;
    localparam int HS_DLY_CYC = 3;
    localparam int WATCHDOG   = 20000;

    localparam int M_IDLE = 0, M_HS = 1, M_WSW = 2, M_LS = 3,
                   M_WLG = 4, M_DLY = 5, M_OC = 6, M_OV = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 1'b0, sw_node_low = 1'b0, lo_gate_low = 1'b0;
    logic oc_trip = 1'b0, cur_zero = 1'b0, ov_trip = 1'b0;
    logic hs_gate_en, ls_gate_en, isense_valid, softstart_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_st = M_IDLE;
    int m_cnt = 0;
    bit m_ss = 1'b0;

    always #10 clk = ~clk;

    phase_gate_sequencer #(.WAIT_MAX(WAIT_MAX), .HS_DLY_CYC(HS_DLY_CYC)) i_phase_gate_sequencer (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .sw_node_low(sw_node_low),
        .lo_gate_low(lo_gate_low), .oc_trip(oc_trip), .cur_zero(cur_zero),
        .ov_trip(ov_trip), .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en),
        .isense_valid(isense_valid), .softstart_req(softstart_req)
    );

    function automatic string tag_of(int st);
        case (st)
            M_IDLE:  return "R1";
            M_HS:    return "R2";
            M_WSW:   return "R3";
            M_LS:    return "R7";
            M_WLG:   return "R5";
            M_DLY:   return "R6";
            M_OC:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: next state from the requirements, per clock edge.
    always @(posedge clk) begin
        int nxt;
        bit ss;
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_ss = 1'b0;
        end else begin
            nxt = m_st; ss = 1'b0;
            if (m_st == M_OV || ov_trip) nxt = M_OV;
            else if (oc_trip) nxt = M_OC;
            else begin
                case (m_st)
                    M_IDLE: if (hs_req) nxt = M_WLG;
                    M_HS:   if (!hs_req) nxt = M_WSW;
                    M_WSW:  if (sw_node_low || m_cnt >= WAIT_MAX - 1) nxt = M_LS;
                    M_LS:   if (hs_req) nxt = M_WLG;
                    M_WLG:  if (!hs_req) nxt = M_LS;
                            else if (lo_gate_low || m_cnt >= WAIT_MAX - 1) nxt = M_DLY;
                    M_DLY:  if (!hs_req) nxt = M_LS;
                            else if (m_cnt >= HS_DLY_CYC - 1) nxt = M_HS;
                    M_OC:   if (cur_zero) begin nxt = M_IDLE; ss = 1'b1; end
                    default: ;
                endcase
            end
            m_cnt = (nxt != m_st) ? 0 : m_cnt + 1;
            m_st = nxt;
            m_ss = ss;
        end
    end

    // Compare outputs with the model on every cycle, away from the edge.
    always @(negedge clk) begin
        bit e_hs, e_ls;
        e_hs = (m_st == M_HS);
        e_ls = (m_st == M_LS || m_st == M_OC || m_st == M_OV);
        check(tag_of(m_st), "hs_gate_en vs model", hs_gate_en, e_hs);
        check(tag_of(m_st), "ls_gate_en vs model", ls_gate_en, e_ls);
        check("R7", "isense_valid vs model", isense_valid, e_ls);
        check("R8", "softstart_req vs model", softstart_req, m_ss);
        check("R11", "gate overlap", hs_gate_en & ls_gate_en, 0);
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL R1 watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_until_hs(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_gate_en && n < 64);
    endtask

    task automatic edges_until_ls(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!ls_gate_en && n < 64);
    endtask

    initial begin
        int n;
        int pulses;
        tick(3);
        check("R1", "reset gates", {hs_gate_en, ls_gate_en, isense_valid, softstart_req}, 0);
        rst_n = 1'b1;
        tick(4);
        check("R1", "idle before request", {hs_gate_en, ls_gate_en}, 0);

        // First turn-on from idle with the lower gate already low.
        hs_req = 1'b1; lo_gate_low = 1'b1;
        edges_until_hs(n);
        check("R5", "idle to upper on edges", n, HS_DLY_CYC + 2);
        tick(3);
        check("R2", "upper held while requested", hs_gate_en, 1);

        // Upper off: wait for the node flag.
        hs_req = 1'b0; lo_gate_low = 1'b0; sw_node_low = 1'b0;
        tick(1);
        check("R2", "upper clears on request drop", hs_gate_en, 0);
        tick(1);
        check("R3", "lower waits for node flag", ls_gate_en, 0);
        sw_node_low = 1'b1;
        tick(1);
        check("R3", "lower on after node flag", ls_gate_en, 1);
        check("R7", "sense valid with lower on", isense_valid, 1);

        // Lower off: wait for the gate flag plus the fixed delay.
        hs_req = 1'b1;
        tick(2);
        check("R5", "dead while gate not low", {hs_gate_en, ls_gate_en}, 0);
        lo_gate_low = 1'b1;
        edges_until_hs(n);
        check("R5", "gate flag to upper on edges", n, HS_DLY_CYC + 1);

        // Stuck node flag: timeout fall-through.
        sw_node_low = 1'b0;
        hs_req = 1'b0;
        edges_until_ls(n);
        check("R4", "node wait timeout edges", n, WAIT_MAX + 1);

        // Request withdrawn while waiting for the gate flag.
        lo_gate_low = 1'b0; hs_req = 1'b1;
        tick(2);
        hs_req = 1'b0;
        tick(1);
        check("R6", "lower back after withdraw in wait", ls_gate_en, 1);

        // Request withdrawn during the fixed delay.
        hs_req = 1'b1; lo_gate_low = 1'b1;
        tick(2);
        hs_req = 1'b0;
        tick(1);
        check("R6", "lower back after withdraw in delay", ls_gate_en, 1);
        check("R6", "upper never on", hs_gate_en, 0);

        // Stuck gate flag: timeout then delay.
        lo_gate_low = 1'b0; hs_req = 1'b1;
        edges_until_hs(n);
        check("R4", "gate wait timeout edges", n, WAIT_MAX + HS_DLY_CYC + 1);

        // Overcurrent from upper-on.
        oc_trip = 1'b1; cur_zero = 1'b1;
        tick(1);
        check("R8", "overcurrent forces lower", {hs_gate_en, ls_gate_en}, 2'b01);
        tick(2);
        check("R8", "hold while trip high", ls_gate_en, 1);
        oc_trip = 1'b0; cur_zero = 1'b0; hs_req = 1'b0;
        tick(2);
        check("R8", "hold until zero current", ls_gate_en, 1);
        cur_zero = 1'b1;
        pulses = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (softstart_req) pulses++;
        end
        check("R8", "soft-start pulse count", pulses, 1);
        check("R8", "idle after hold", {hs_gate_en, ls_gate_en}, 0);
        cur_zero = 1'b0;

        // Over-voltage together with overcurrent.
        hs_req = 1'b1; lo_gate_low = 1'b1;
        edges_until_hs(n);
        ov_trip = 1'b1; oc_trip = 1'b1;
        tick(1);
        check("R10", "ov wins over oc", {hs_gate_en, ls_gate_en}, 2'b01);
        ov_trip = 1'b0; oc_trip = 1'b0; cur_zero = 1'b1;
        pulses = 0;
        for (int k = 0; k < 12; k++) begin
            hs_req = k[0];
            sw_node_low = k[1];
            @(negedge clk);
            if (softstart_req) pulses++;
        end
        check("R9", "latched lower on", {hs_gate_en, ls_gate_en}, 2'b01);
        check("R9", "no soft-start while latched", pulses, 0);
        rst_n = 1'b0; hs_req = 1'b0; cur_zero = 1'b0; sw_node_low = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(1);
        check("R9", "reset clears latch", {hs_gate_en, ls_gate_en}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule